// File: doc/BRIEF.md
# Two-Level Next-Block Address Cache

This block supplies the fetch unit with the start addresses of the next two basic blocks from a single fetch address per cycle. Each table entry stores a small tree of candidate addresses. The first level holds the taken and not-taken successors of the first branch. The second level holds the four successors that follow a second branch on either of those paths. Two predicted direction bits, one per branch level, pick one path through the tree. The block reports the chosen addresses together with validity and branch-kind information.

The table is direct-mapped and indexed by the fetch address above the word offset. A lookup is purely combinational from stored state. When a branch resolves, the update port writes one address slot with its branch valid and kind fields. The slot is chosen by the update level and the resolved outcome path. An update at the first level allocates the entry on a miss. An update at the second level only refines an entry that is already present.

Top module: `next_block_tree_cache`

## Requirements
- R1: After reset every lookup misses: hit_o, blk0_valid_o and blk1_valid_o are 0, both addresses are 0 and both kinds are 2'b00.
- R2: The index is fetch_addr_i[OFF_W+IDX_W-1:OFF_W] and the tag is the bits above it. A lookup hits only when the indexed entry is allocated and its tag matches. On a miss all outputs are 0 and both kinds are 2'b00.
- R3: A first-level update (upd_level_i=0) to an address that misses allocates the entry. The entry is cleared, the tag is stored, and only the primary branch fields and the one first-level slot selected by upd_pri_taken_i are written.
- R4: pred_pri_i=1 selects the taken first-level slot and 0 selects the not-taken slot. blk0_valid_o is 1 only on a hit with the primary branch valid and the selected slot written. blk0_addr_o is 0 when blk0_valid_o is 0.
- R5: The pair {pred_pri_i, pred_sec_i} selects one of four second-level slots, and blk1_addr_o returns the address written for that same outcome pair.
- R6: blk1_valid_o is 1 only when blk0_valid_o is 1, the secondary branch on the selected primary path is valid, and the selected second-level slot is written. Otherwise blk1_addr_o is 0.
- R7: A second-level update (upd_level_i=1) to an address that misses changes nothing.
- R8: A second-level update that hits sets the secondary valid and kind for path upd_pri_taken_i. It also writes the slot {upd_pri_taken_i, upd_sec_taken_i}. All other fields are kept.
- R9: Kind codes are 2'b00 none, 2'b01 conditional, 2'b10 unconditional and 2'b11 return. pri_kind_o shows the stored primary kind when the lookup hits and the primary branch is valid. sec_kind_o shows the secondary kind on the selected path when that secondary is also valid. Otherwise each kind output is 2'b00.
- R10: A first-level update that hits overwrites the primary kind and one first-level slot. All second-level state is kept.
- R11: A first-level update whose tag differs from the entry at that index replaces the entry, and the old address misses afterwards.
- R12: A lookup in the same cycle as an update returns the contents from before that update. The new contents are visible from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| fetch_addr_i | input | ADDR_W | Lookup fetch address |
| pred_pri_i | input | 1 | Predicted direction of first branch (1 = taken) |
| pred_sec_i | input | 1 | Predicted direction of second branch (1 = taken) |
| hit_o | output | 1 | Entry allocated with matching tag |
| blk0_valid_o | output | 1 | First next-block address valid |
| blk0_addr_o | output | ADDR_W | First next-block start address |
| pri_kind_o | output | 2 | Kind of first branch |
| blk1_valid_o | output | 1 | Second next-block address valid |
| blk1_addr_o | output | ADDR_W | Second next-block start address |
| sec_kind_o | output | 2 | Kind of second branch on selected path |
| upd_en_i | input | 1 | Update strobe |
| upd_addr_i | input | ADDR_W | Fetch address of the entry to update |
| upd_level_i | input | 1 | 0 = first-level slot, 1 = second-level slot |
| upd_pri_taken_i | input | 1 | Resolved outcome of first branch |
| upd_sec_taken_i | input | 1 | Resolved outcome of second branch (level 1 only) |
| upd_target_i | input | ADDR_W | Address written into the selected slot |
| upd_kind_i | input | 2 | Kind written for the branch at that level |

## Verification
The lookup is tried with all four prediction pairs on one entry that has every slot written with a distinct address. This catches any swap of the taken and not-taken legs or of the two second-level bits. Partly filled entries, where one path lacks a secondary branch or one slot was never written, separate the validity chain of the second block from that of the first. Second-level updates to absent entries, evictions by a second tag on the same index, and updates in the same cycle as a lookup expose wrong allocation rules and early visibility. Random updates and lookups over a small pool of tags and indexes cover mixed histories against a bench model.

// File: rtl/nbt_pkg.sv
package nbt_pkg;
  typedef enum logic [1:0] {
    KIND_NONE   = 2'b00,
    KIND_COND   = 2'b01,
    KIND_UNCOND = 2'b10,
    KIND_RET    = 2'b11
  } br_kind_e;

  localparam int unsigned PATHS_L1 = 2;
  localparam int unsigned PATHS_L2 = 4;
endpackage

// File: rtl/nbt_addr_split.sv
module nbt_addr_split #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned IDX_W  = 5,
  parameter int unsigned OFF_W  = 2,
  localparam int unsigned TAG_W = ADDR_W - IDX_W - OFF_W
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic [IDX_W-1:0]  idx_o,
  output logic [TAG_W-1:0]  tag_o
);
  assign idx_o = addr_i[OFF_W+IDX_W-1:OFF_W];
  assign tag_o = addr_i[ADDR_W-1:OFF_W+IDX_W];
endmodule

// File: rtl/nbt_table.sv
module nbt_table
  import nbt_pkg::*;
#(
  parameter int unsigned ADDR_W  = 32,
  parameter int unsigned ENTRIES = 32,
  parameter int unsigned TAG_W   = 25,
  localparam int unsigned IDX_W  = $clog2(ENTRIES)
) (
  input  logic                              clk_i,
  input  logic                              rst_ni,
  // lookup read port
  input  logic [IDX_W-1:0]                  rd_idx_i,
  output logic                              rd_vld_o,
  output logic [TAG_W-1:0]                  rd_tag_o,
  output logic                              rd_p_vld_o,
  output br_kind_e                          rd_p_kind_o,
  output logic [PATHS_L1-1:0]               rd_s_vld_o,
  output logic [PATHS_L1-1:0][1:0]          rd_s_kind_o,
  output logic [PATHS_L1-1:0]               rd_l1_vld_o,
  output logic [PATHS_L1-1:0][ADDR_W-1:0]   rd_l1_addr_o,
  output logic [PATHS_L2-1:0]               rd_l2_vld_o,
  output logic [PATHS_L2-1:0][ADDR_W-1:0]   rd_l2_addr_o,
  // tag probe for update
  input  logic [IDX_W-1:0]                  pr_idx_i,
  output logic                              pr_vld_o,
  output logic [TAG_W-1:0]                  pr_tag_o,
  // write port
  input  logic                              wr_en_i,
  input  logic                              wr_alloc_i,
  input  logic [IDX_W-1:0]                  wr_idx_i,
  input  logic [TAG_W-1:0]                  wr_tag_i,
  input  logic                              wr_level_i,
  input  logic                              wr_pri_i,
  input  logic                              wr_sec_i,
  input  logic [ADDR_W-1:0]                 wr_addr_i,
  input  br_kind_e                          wr_kind_i
);
  typedef struct packed {
    logic                            vld;
    logic [TAG_W-1:0]                tag;
    logic                            p_vld;
    logic [1:0]                      p_kind;
    logic [PATHS_L1-1:0]             s_vld;
    logic [PATHS_L1-1:0][1:0]        s_kind;
    logic [PATHS_L1-1:0]             l1_vld;
    logic [PATHS_L1-1:0][ADDR_W-1:0] l1_addr;
    logic [PATHS_L2-1:0]             l2_vld;
    logic [PATHS_L2-1:0][ADDR_W-1:0] l2_addr;
  } ent_t;

  ent_t mem [ENTRIES];
  logic [1:0] l2_sel;

  assign l2_sel = {wr_pri_i, wr_sec_i};

  for (genvar e = 0; e < ENTRIES; e++) begin : g_ent
    ent_t q;
    logic hit_wr;
    assign hit_wr = wr_en_i && (wr_idx_i == IDX_W'(e));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        q <= '0;
      end else if (hit_wr) begin
        if (wr_alloc_i) begin
          q.vld    <= 1'b1;
          q.tag    <= wr_tag_i;
          q.p_vld  <= 1'b0;
          q.p_kind <= 2'b00;
          q.s_vld  <= '0;
          q.s_kind <= '0;
          q.l1_vld <= '0;
          q.l2_vld <= '0;
        end
        if (!wr_level_i) begin
          q.p_vld            <= 1'b1;
          q.p_kind           <= wr_kind_i;
          q.l1_vld[wr_pri_i]  <= 1'b1;
          q.l1_addr[wr_pri_i] <= wr_addr_i;
        end else begin
          q.s_vld[wr_pri_i]   <= 1'b1;
          q.s_kind[wr_pri_i]  <= wr_kind_i;
          q.l2_vld[l2_sel]    <= 1'b1;
          q.l2_addr[l2_sel]   <= wr_addr_i;
        end
      end
    end

    assign mem[e] = q;
  end

  ent_t rd_ent;
  ent_t pr_ent;
  assign rd_ent = mem[rd_idx_i];
  assign pr_ent = mem[pr_idx_i];

  assign rd_vld_o     = rd_ent.vld;
  assign rd_tag_o     = rd_ent.tag;
  assign rd_p_vld_o   = rd_ent.p_vld;
  assign rd_p_kind_o  = br_kind_e'(rd_ent.p_kind);
  assign rd_s_vld_o   = rd_ent.s_vld;
  assign rd_s_kind_o  = rd_ent.s_kind;
  assign rd_l1_vld_o  = rd_ent.l1_vld;
  assign rd_l1_addr_o = rd_ent.l1_addr;
  assign rd_l2_vld_o  = rd_ent.l2_vld;
  assign rd_l2_addr_o = rd_ent.l2_addr;

  assign pr_vld_o = pr_ent.vld;
  assign pr_tag_o = pr_ent.tag;
endmodule

// File: rtl/nbt_select.sv
module nbt_select
  import nbt_pkg::*;
#(
  parameter int unsigned ADDR_W = 32
) (
  input  logic                            hit_i,
  input  logic                            pri_i,
  input  logic                            sec_i,
  input  logic                            p_vld_i,
  input  br_kind_e                        p_kind_i,
  input  logic [PATHS_L1-1:0]             s_vld_i,
  input  logic [PATHS_L1-1:0][1:0]        s_kind_i,
  input  logic [PATHS_L1-1:0]             l1_vld_i,
  input  logic [PATHS_L1-1:0][ADDR_W-1:0] l1_addr_i,
  input  logic [PATHS_L2-1:0]             l2_vld_i,
  input  logic [PATHS_L2-1:0][ADDR_W-1:0] l2_addr_i,
  output logic                            blk0_valid_o,
  output logic [ADDR_W-1:0]               blk0_addr_o,
  output br_kind_e                        pri_kind_o,
  output logic                            blk1_valid_o,
  output logic [ADDR_W-1:0]               blk1_addr_o,
  output br_kind_e                        sec_kind_o
);
  logic       pri_live;
  logic       sec_live;
  logic [1:0] leaf;

  assign leaf     = {pri_i, sec_i};
  assign pri_live = hit_i && p_vld_i;
  assign sec_live = pri_live && s_vld_i[pri_i];

  always_comb begin
    blk0_valid_o = pri_live && l1_vld_i[pri_i];
    blk1_valid_o = blk0_valid_o && sec_live && l2_vld_i[leaf];
    blk0_addr_o  = blk0_valid_o ? l1_addr_i[pri_i] : '0;
    blk1_addr_o  = blk1_valid_o ? l2_addr_i[leaf]  : '0;
    pri_kind_o   = pri_live ? p_kind_i : KIND_NONE;
    sec_kind_o   = sec_live ? br_kind_e'(s_kind_i[pri_i]) : KIND_NONE;
  end
endmodule

// File: rtl/next_block_tree_cache.sv
module next_block_tree_cache
  import nbt_pkg::*;
#(
  parameter int unsigned ADDR_W  = 32,
  parameter int unsigned ENTRIES = 32,
  parameter int unsigned OFF_W   = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] fetch_addr_i,
  input  logic              pred_pri_i,
  input  logic              pred_sec_i,
  output logic              hit_o,
  output logic              blk0_valid_o,
  output logic [ADDR_W-1:0] blk0_addr_o,
  output logic [1:0]        pri_kind_o,
  output logic              blk1_valid_o,
  output logic [ADDR_W-1:0] blk1_addr_o,
  output logic [1:0]        sec_kind_o,
  input  logic              upd_en_i,
  input  logic [ADDR_W-1:0] upd_addr_i,
  input  logic              upd_level_i,
  input  logic              upd_pri_taken_i,
  input  logic              upd_sec_taken_i,
  input  logic [ADDR_W-1:0] upd_target_i,
  input  logic [1:0]        upd_kind_i
);
  localparam int unsigned IDX_W = $clog2(ENTRIES);
  localparam int unsigned TAG_W = ADDR_W - IDX_W - OFF_W;

  logic [IDX_W-1:0] lk_idx, up_idx;
  logic [TAG_W-1:0] lk_tag, up_tag;

  nbt_addr_split #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .OFF_W(OFF_W)) u_split_lk (
    .addr_i(fetch_addr_i), .idx_o(lk_idx), .tag_o(lk_tag)
  );
  nbt_addr_split #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .OFF_W(OFF_W)) u_split_up (
    .addr_i(upd_addr_i), .idx_o(up_idx), .tag_o(up_tag)
  );

  logic                            rd_vld, rd_p_vld, pr_vld;
  logic [TAG_W-1:0]                rd_tag, pr_tag;
  br_kind_e                        rd_p_kind;
  logic [PATHS_L1-1:0]             rd_s_vld, rd_l1_vld;
  logic [PATHS_L1-1:0][1:0]        rd_s_kind;
  logic [PATHS_L1-1:0][ADDR_W-1:0] rd_l1_addr;
  logic [PATHS_L2-1:0]             rd_l2_vld;
  logic [PATHS_L2-1:0][ADDR_W-1:0] rd_l2_addr;

  logic up_match, wr_en, wr_alloc, lk_hit;

  assign up_match = pr_vld && (pr_tag == up_tag);
  // second-level writes never allocate
  assign wr_en    = upd_en_i && (!upd_level_i || up_match);
  assign wr_alloc = !upd_level_i && !up_match;
  assign lk_hit   = rd_vld && (rd_tag == lk_tag);

  nbt_table #(.ADDR_W(ADDR_W), .ENTRIES(ENTRIES), .TAG_W(TAG_W)) u_table (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .rd_idx_i     (lk_idx),
    .rd_vld_o     (rd_vld),
    .rd_tag_o     (rd_tag),
    .rd_p_vld_o   (rd_p_vld),
    .rd_p_kind_o  (rd_p_kind),
    .rd_s_vld_o   (rd_s_vld),
    .rd_s_kind_o  (rd_s_kind),
    .rd_l1_vld_o  (rd_l1_vld),
    .rd_l1_addr_o (rd_l1_addr),
    .rd_l2_vld_o  (rd_l2_vld),
    .rd_l2_addr_o (rd_l2_addr),
    .pr_idx_i     (up_idx),
    .pr_vld_o     (pr_vld),
    .pr_tag_o     (pr_tag),
    .wr_en_i      (wr_en),
    .wr_alloc_i   (wr_alloc),
    .wr_idx_i     (up_idx),
    .wr_tag_i     (up_tag),
    .wr_level_i   (upd_level_i),
    .wr_pri_i     (upd_pri_taken_i),
    .wr_sec_i     (upd_sec_taken_i),
    .wr_addr_i    (upd_target_i),
    .wr_kind_i    (br_kind_e'(upd_kind_i))
  );

  br_kind_e pk, sk;

  nbt_select #(.ADDR_W(ADDR_W)) u_select (
    .hit_i        (lk_hit),
    .pri_i        (pred_pri_i),
    .sec_i        (pred_sec_i),
    .p_vld_i      (rd_p_vld),
    .p_kind_i     (rd_p_kind),
    .s_vld_i      (rd_s_vld),
    .s_kind_i     (rd_s_kind),
    .l1_vld_i     (rd_l1_vld),
    .l1_addr_i    (rd_l1_addr),
    .l2_vld_i     (rd_l2_vld),
    .l2_addr_i    (rd_l2_addr),
    .blk0_valid_o (blk0_valid_o),
    .blk0_addr_o  (blk0_addr_o),
    .pri_kind_o   (pk),
    .blk1_valid_o (blk1_valid_o),
    .blk1_addr_o  (blk1_addr_o),
    .sec_kind_o   (sk)
  );

  assign hit_o      = lk_hit;
  assign pri_kind_o = pk;
  assign sec_kind_o = sk;
endmodule

// File: rtl/nbt_checker.sv
module nbt_checker #(
  parameter int unsigned ADDR_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [ADDR_W-1:0] fetch_addr_i,
  input logic              pred_pri_i,
  input logic              hit_o,
  input logic              blk0_valid_o,
  input logic [ADDR_W-1:0] blk0_addr_o,
  input logic [1:0]        pri_kind_o,
  input logic              blk1_valid_o,
  input logic [ADDR_W-1:0] blk1_addr_o,
  input logic [1:0]        sec_kind_o,
  input logic              upd_en_i,
  input logic [ADDR_W-1:0] upd_addr_i,
  input logic              upd_level_i,
  input logic              upd_pri_taken_i,
  input logic [ADDR_W-1:0] upd_target_i
);
  assert_miss_quiet_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hit_o |-> (!blk0_valid_o && !blk1_valid_o && blk0_addr_o == '0 &&
                blk1_addr_o == '0 && pri_kind_o == 2'b00 && sec_kind_o == 2'b00));

  assert_blk0_needs_hit_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    blk0_valid_o |-> hit_o);

  assert_blk1_needs_blk0_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    blk1_valid_o |-> blk0_valid_o);

  assert_l1_write_visible_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_en_i && !upd_level_i) |=>
      ((fetch_addr_i == $past(upd_addr_i) && pred_pri_i == $past(upd_pri_taken_i)) ->
       (hit_o && blk0_valid_o && blk0_addr_o == $past(upd_target_i))));
endmodule

bind next_block_tree_cache nbt_checker #(.ADDR_W(ADDR_W)) u_nbt_checker (
  .clk_i           (clk_i),
  .rst_ni          (rst_ni),
  .fetch_addr_i    (fetch_addr_i),
  .pred_pri_i      (pred_pri_i),
  .hit_o           (hit_o),
  .blk0_valid_o    (blk0_valid_o),
  .blk0_addr_o     (blk0_addr_o),
  .pri_kind_o      (pri_kind_o),
  .blk1_valid_o    (blk1_valid_o),
  .blk1_addr_o     (blk1_addr_o),
  .sec_kind_o      (sec_kind_o),
  .upd_en_i        (upd_en_i),
  .upd_addr_i      (upd_addr_i),
  .upd_level_i     (upd_level_i),
  .upd_pri_taken_i (upd_pri_taken_i),
  .upd_target_i    (upd_target_i)
);

// File: tb/next_block_tree_cache_test.sv
`timescale 1ns/1ps
module next_block_tree_cache_test;
  localparam int AW = 32;
  localparam int NE = 32;
  localparam int OFF = 2;
  localparam int IW = 5;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic          rst_n;
  logic [AW-1:0] fetch_addr;
  logic          pp, ps;
  logic          hit, b0v, b1v;
  logic [AW-1:0] b0a, b1a;
  logic [1:0]    pk, sk;
  logic          ue, ul, upt, ust;
  logic [AW-1:0] ua, ut;
  logic [1:0]    uk;

  next_block_tree_cache uut (
    .clk_i(clk), .rst_ni(rst_n), .fetch_addr_i(fetch_addr),
    .pred_pri_i(pp), .pred_sec_i(ps), .hit_o(hit),
    .blk0_valid_o(b0v), .blk0_addr_o(b0a), .pri_kind_o(pk),
    .blk1_valid_o(b1v), .blk1_addr_o(b1a), .sec_kind_o(sk),
    .upd_en_i(ue), .upd_addr_i(ua), .upd_level_i(ul),
    .upd_pri_taken_i(upt), .upd_sec_taken_i(ust),
    .upd_target_i(ut), .upd_kind_i(uk)
  );

  int checks = 0;
  int errors = 0;

  // reference model
  bit            m_vld [NE];
  bit [AW-1:0]   m_tag [NE];
  bit            m_pv  [NE];
  bit [1:0]      m_pk  [NE];
  bit            m_sv  [NE][2];
  bit [1:0]      m_sk  [NE][2];
  bit            m_l1v [NE][2];
  bit [AW-1:0]   m_l1a [NE][2];
  bit            m_l2v [NE][4];
  bit [AW-1:0]   m_l2a [NE][4];

  function automatic int idx_of(logic [AW-1:0] a);
    return int'(a[OFF+IW-1:OFF]);
  endfunction
  function automatic logic [AW-1:0] tag_of(logic [AW-1:0] a);
    return a >> (OFF + IW);
  endfunction
  function automatic logic [AW-1:0] mk(int tag, int idx);
    return (AW'(tag) << (OFF + IW)) | (AW'(idx) << OFF);
  endfunction

  task automatic chk(string req, string what, logic [AW-1:0] act, logic [AW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic check_lookup(string req);
    int i;
    bit e_hit, e_b0v, e_b1v, pl, sl;
    logic [AW-1:0] e_b0a, e_b1a;
    logic [1:0] e_pk, e_sk;
    int leaf;
    i = idx_of(fetch_addr);
    leaf = {pp, ps};
    e_hit = m_vld[i] && (m_tag[i] == tag_of(fetch_addr));
    pl = e_hit && m_pv[i];
    sl = pl && m_sv[i][pp];
    e_b0v = pl && m_l1v[i][pp];
    e_b1v = e_b0v && sl && m_l2v[i][leaf];
    e_b0a = e_b0v ? m_l1a[i][pp] : '0;
    e_b1a = e_b1v ? m_l2a[i][leaf] : '0;
    e_pk = pl ? m_pk[i] : 2'b00;
    e_sk = sl ? m_sk[i][pp] : 2'b00;
    chk(req, "hit", AW'(hit), AW'(e_hit));
    chk(req, "blk0_valid", AW'(b0v), AW'(e_b0v));
    chk(req, "blk0_addr", b0a, e_b0a);
    chk(req, "pri_kind", AW'(pk), AW'(e_pk));
    chk(req, "blk1_valid", AW'(b1v), AW'(e_b1v));
    chk(req, "blk1_addr", b1a, e_b1a);
    chk(req, "sec_kind", AW'(sk), AW'(e_sk));
  endtask

  task automatic model_update();
    int i;
    bit match;
    if (!ue) return;
    i = idx_of(ua);
    match = m_vld[i] && (m_tag[i] == tag_of(ua));
    if (ul) begin
      if (!match) return;
      m_sv[i][upt] = 1'b1;
      m_sk[i][upt] = uk;
      m_l2v[i][{upt, ust}] = 1'b1;
      m_l2a[i][{upt, ust}] = ut;
    end else begin
      if (!match) begin
        m_vld[i] = 1'b1; m_tag[i] = tag_of(ua); m_pv[i] = 1'b0; m_pk[i] = 2'b00;
        for (int k = 0; k < 2; k++) begin m_sv[i][k] = 0; m_sk[i][k] = 0; m_l1v[i][k] = 0; end
        for (int k = 0; k < 4; k++) m_l2v[i][k] = 0;
      end
      m_pv[i] = 1'b1;
      m_pk[i] = uk;
      m_l1v[i][upt] = 1'b1;
      m_l1a[i][upt] = ut;
    end
  endtask

  // inputs set just after a falling edge; check 1 ns later; model follows the rising edge
  task automatic step(string req);
    #1;
    check_lookup(req);
    @(posedge clk);
    model_update();
    @(negedge clk);
    ue = 1'b0;
  endtask

  task automatic look(logic [AW-1:0] a, bit p, bit s, string req);
    fetch_addr = a; pp = p; ps = s; ue = 1'b0;
    step(req);
  endtask

  task automatic upd(logic [AW-1:0] a, bit lvl, bit pt, bit st, logic [AW-1:0] t,
                     logic [1:0] k, string req);
    ue = 1'b1; ua = a; ul = lvl; upt = pt; ust = st; ut = t; uk = k;
    step(req);
  endtask

  bit done = 0;
  initial begin
    #(4 * 200000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [AW-1:0] a_ent, b_ent, c_ent, a_alias;
    int seed_sink;
    for (int i = 0; i < NE; i++) begin
      m_vld[i] = 0; m_pv[i] = 0; m_pk[i] = 0;
      for (int k = 0; k < 2; k++) begin m_sv[i][k] = 0; m_sk[i][k] = 0; m_l1v[i][k] = 0; m_l1a[i][k] = 0; end
      for (int k = 0; k < 4; k++) begin m_l2v[i][k] = 0; m_l2a[i][k] = 0; end
    end
    rst_n = 1'b0; fetch_addr = '0; pp = 0; ps = 0;
    ue = 0; ua = '0; ul = 0; upt = 0; ust = 0; ut = '0; uk = 2'b00;
    seed_sink = $urandom(32'd1357);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    a_ent   = mk(1, 3);
    b_ent   = mk(5, 9);
    c_ent   = mk(7, 12);
    a_alias = mk(2, 3);

    // R1: empty after reset
    look(a_ent, 1, 1, "R1");
    look(mk(0, 0), 0, 0, "R1");

    // R12: lookup during the allocating update still misses
    fetch_addr = a_ent; pp = 1; ps = 0;
    upd(a_ent, 0, 1, 0, 32'h0000_1000, 2'b01, "R12");
    // R3 / R4: taken slot now visible, not-taken slot unwritten
    look(a_ent, 1, 0, "R3");
    look(a_ent, 0, 0, "R4");

    // R7: second-level update to an absent entry is dropped
    upd(b_ent, 1, 0, 1, 32'h0000_BEEF, 2'b11, "R7");
    look(b_ent, 0, 1, "R7");
    upd(b_ent, 0, 0, 0, 32'h0000_2000, 2'b10, "R7");
    look(b_ent, 0, 1, "R7");

    // R8 / R5 / R9: fill the whole tree of a_ent
    upd(a_ent, 1, 1, 1, 32'h0000_3110, 2'b11, "R8");
    upd(a_ent, 1, 1, 0, 32'h0000_3100, 2'b11, "R8");
    upd(a_ent, 0, 0, 0, 32'h0000_1800, 2'b01, "R10");
    upd(a_ent, 1, 0, 0, 32'h0000_3000, 2'b10, "R8");
    upd(a_ent, 1, 0, 1, 32'h0000_3010, 2'b10, "R8");
    look(a_ent, 1, 1, "R5");
    look(a_ent, 1, 0, "R5");
    look(a_ent, 0, 1, "R5");
    look(a_ent, 0, 0, "R5");
    look(a_ent, 1, 1, "R9");

    // R6: secondary only on the not-taken path
    upd(c_ent, 0, 1, 0, 32'h0000_4000, 2'b01, "R6");
    upd(c_ent, 1, 0, 0, 32'h0000_4400, 2'b01, "R6");
    look(c_ent, 1, 1, "R6");
    look(c_ent, 0, 0, "R6");
    look(c_ent, 0, 1, "R6");

    // R10: primary rewrite keeps the second level
    upd(a_ent, 0, 1, 0, 32'h0000_1004, 2'b10, "R10");
    look(a_ent, 1, 1, "R10");
    look(a_ent, 0, 1, "R10");

    // R11: alias on same index evicts
    upd(a_alias, 0, 1, 0, 32'h0000_5000, 2'b01, "R11");
    look(a_ent, 1, 1, "R11");
    look(a_alias, 1, 1, "R11");

    // R2: random mix over a small tag/index pool
    for (int n = 0; n < 3000; n++) begin
      logic [AW-1:0] ra;
      ra = mk(int'($urandom_range(3, 0)), int'($urandom_range(3, 0)) * 5);
      fetch_addr = mk(int'($urandom_range(3, 0)), int'($urandom_range(3, 0)) * 5);
      pp = 1'($urandom); ps = 1'($urandom);
      if ($urandom_range(1, 0) == 1) begin
        upd(ra, 1'($urandom), 1'($urandom), 1'($urandom),
            $urandom & 32'hFFFF_FFFC, 2'($urandom), "R2");
      end else begin
        step("R2");
      end
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule